// File: doc/BRIEF.md
# Dual-Channel DMA Control Register File

This block is the software-visible control and status register file of a two-channel DMA engine. One channel serves a SCSI controller and the other an Ethernet controller. A simple single-cycle register bus reads and writes eight 32-bit words. Some control writes have side effects: they drop an interrupt line or pulse a peripheral reset.

On the SCSI channel, the engine reports each completed burst as a strobe with a byte count. The block shows the current memory address, advances it by the count, and latches the interrupt status. The SCSI peripheral can also raise or clear its interrupt directly. On the Ethernet channel, the block builds memory addresses by ORing the peripheral address with a high-address register. It also optionally exchanges the bytes of each 16-bit halfword moving in either direction.

Bus mastering, address translation and the peripherals themselves sit outside the block.

Top module: `dual_dma_ctrl`

## Requirements
- R1: After reset, registers 0 (SCSI control) and 4 (Ethernet control) hold 0xA0000000. Registers 1, 2, 3, 5, 6 and 7 hold zero. Both interrupt outputs and both reset outputs are low.
- R2: Byte address bits [4:2] select the register. Bits [1:0] and the bits above bit 4 are ignored, so the eight words alias across the bus address range. A write stores its data in the next cycle. A read returns the stored word combinationally and changes no state.
- R3: Bit 8 of register 0 drives `scsi_dir_o` and bit 8 of register 4 drives `net_dir_o`; a 1 means transfers write to memory.
- R4: A bus write to register 1 sets bit 26 (the loaded flag) of register 0 in the same update. The other bits of register 0 are left as they were.
- R5: `scsi_mem_addr_o` shows register 1. When `scsi_xfer_i` is high, register 1 grows by `scsi_len_i`, wrapping modulo 2^32, and bit 0 (interrupt status) of register 0 is set. The interrupt output is not touched. If a bus write to register 1 falls in the same cycle, the written value is stored instead of the sum, but the status bit and the loaded flag are still set.
- R6: `scsi_irq_raise_i` sets bit 0 of register 0 and `scsi_irq_o`, and `scsi_irq_clear_i` clears both, one cycle later. When both are high together, the raise wins.
- R7: A write to register 0 with bit 4 (interrupt enable) clear lowers `scsi_irq_o` in the next cycle, unless a raise arrives in the same cycle. A write with bit 4 set leaves `scsi_irq_o` unchanged.
- R8: A write to register 0 with bit 7 set makes `scsi_rst_o` high for exactly the following cycle. The same holds for register 4 and `net_rst_o`. The written word, including bit 7, is still stored.
- R9: `net_irq_set_i` sets `net_irq_o` and bit 0 of register 4. A write to register 4 with bit 4 clear lowers `net_irq_o` in the next cycle, unless a set arrives in the same cycle.
- R10: `net_mem_addr_o` equals `net_addr_i` ORed with register 7, combinationally.
- R11: When `net_swap_i` is 1, the two bytes of each 16-bit halfword are exchanged from `net_rdata_i` to `net_rdata_o` and from `net_wdata_i` to `net_wdata_o`. When it is 0, data passes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | BUS_AW (8) | Register bus byte address |
| bus_we_i | input | 1 | Register write strobe |
| bus_wdata_i | input | DATA_W (32) | Register write data |
| bus_rdata_o | output | DATA_W (32) | Register read data |
| scsi_xfer_i | input | 1 | SCSI burst completed |
| scsi_len_i | input | LEN_W (24) | Byte count of the completed burst |
| scsi_irq_raise_i | input | 1 | SCSI peripheral interrupt raise |
| scsi_irq_clear_i | input | 1 | SCSI peripheral interrupt clear |
| scsi_mem_addr_o | output | DATA_W (32) | SCSI channel memory address |
| scsi_dir_o | output | 1 | SCSI direction, 1 = write to memory |
| scsi_irq_o | output | 1 | SCSI channel interrupt |
| scsi_rst_o | output | 1 | SCSI peripheral reset pulse |
| net_irq_set_i | input | 1 | Ethernet peripheral interrupt request |
| net_addr_i | input | DATA_W (32) | Ethernet peripheral address |
| net_mem_addr_o | output | DATA_W (32) | Ethernet channel memory address |
| net_dir_o | output | 1 | Ethernet direction, 1 = write to memory |
| net_swap_i | input | 1 | Halfword byte swap enable |
| net_rdata_i | input | NET_W (16) | Data read from memory |
| net_rdata_o | output | NET_W (16) | Data to the Ethernet peripheral |
| net_wdata_i | input | NET_W (16) | Data from the Ethernet peripheral |
| net_wdata_o | output | NET_W (16) | Data written to memory |
| net_irq_o | output | 1 | Ethernet channel interrupt |
| net_rst_o | output | 1 | Ethernet peripheral reset pulse |

## Verification
The bench stresses two pairs of functions that can fall in the same cycle. The first pair is a completed SCSI burst together with a bus write to the address register. The bench checks that the written address survives while the status and loaded bits are still set. The second pair is an interrupt raise together with a control write that clears interrupt enable (and a raise together with a clear request). Here the interrupt must stay high. A behavioural model applies the priorities above, and its expected read data, addresses and output lines are compared with the design on every clock.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  localparam int REG_SCSI_CTRL = 0;
  localparam int REG_SCSI_ADDR = 1;
  localparam int REG_NET_CTRL  = 4;
  localparam int REG_NET_HIGH  = 7;

  localparam int B_INT    = 0;
  localparam int B_IEN    = 4;
  localparam int B_RST    = 7;
  localparam int B_DIR    = 8;
  localparam int B_LOADED = 26;

  localparam logic [31:0] VERSION_CODE = 32'hA000_0000;
endpackage

// File: rtl/ddc_irq_line.sv
module ddc_irq_line (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;   // set beats clear
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/ddc_swap.sv
module ddc_swap #(
  parameter int W = 16
) (
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o
);
  localparam int HALVES = W / 16;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign d_o[h*16 +: 16] = en_i ? {d_i[h*16 +: 8], d_i[h*16+8 +: 8]}
                                  : d_i[h*16 +: 16];
  end
endmodule

// File: rtl/ddc_reg_file.sv
module ddc_reg_file
  import ddc_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int LEN_W    = 24,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              xfer_i,
  input  logic [LEN_W-1:0]  xfer_len_i,
  input  logic              scsi_raise_i,
  input  logic              scsi_clr_i,
  input  logic              net_set_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] scsi_ctrl_o,
  output logic [DATA_W-1:0] scsi_addr_o,
  output logic [DATA_W-1:0] net_ctrl_o,
  output logic [DATA_W-1:0] net_high_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic [DATA_W-1:0] regs_d [NUM_REGS];
  logic              wr_addr_reg;

  assign wr_addr_reg = wr_en_i && (idx_i == IDX_W'(REG_SCSI_ADDR));

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) regs_d[i] = regs_q[i];
    if (wr_en_i) regs_d[idx_i] = wr_data_i;
    if (xfer_i && !wr_addr_reg)
      regs_d[REG_SCSI_ADDR] = regs_q[REG_SCSI_ADDR] + DATA_W'(xfer_len_i);
    if (wr_addr_reg)             regs_d[REG_SCSI_CTRL][B_LOADED] = 1'b1;
    if (scsi_clr_i)              regs_d[REG_SCSI_CTRL][B_INT]    = 1'b0;
    if (scsi_raise_i || xfer_i)  regs_d[REG_SCSI_CTRL][B_INT]    = 1'b1;
    if (net_set_i)               regs_d[REG_NET_CTRL][B_INT]     = 1'b1;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_VAL =
      (g == REG_SCSI_CTRL || g == REG_NET_CTRL) ? DATA_W'(VERSION_CODE) : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[g] <= RST_VAL;
      else         regs_q[g] <= regs_d[g];
    end
  end

  assign rd_data_o   = regs_q[idx_i];
  assign scsi_ctrl_o = regs_q[REG_SCSI_CTRL];
  assign scsi_addr_o = regs_q[REG_SCSI_ADDR];
  assign net_ctrl_o  = regs_q[REG_NET_CTRL];
  assign net_high_o  = regs_q[REG_NET_HIGH];
endmodule

// File: rtl/dual_dma_ctrl.sv
module dual_dma_ctrl
  import ddc_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int BUS_AW   = 8,
  parameter int LEN_W    = 24,
  parameter int NET_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              scsi_xfer_i,
  input  logic [LEN_W-1:0]  scsi_len_i,
  input  logic              scsi_irq_raise_i,
  input  logic              scsi_irq_clear_i,
  output logic [DATA_W-1:0] scsi_mem_addr_o,
  output logic              scsi_dir_o,
  output logic              scsi_irq_o,
  output logic              scsi_rst_o,
  input  logic              net_irq_set_i,
  input  logic [DATA_W-1:0] net_addr_i,
  output logic [DATA_W-1:0] net_mem_addr_o,
  output logic              net_dir_o,
  input  logic              net_swap_i,
  input  logic [NET_W-1:0]  net_rdata_i,
  output logic [NET_W-1:0]  net_rdata_o,
  input  logic [NET_W-1:0]  net_wdata_i,
  output logic [NET_W-1:0]  net_wdata_o,
  output logic              net_irq_o,
  output logic              net_rst_o
);
  localparam int IDX_W  = $clog2(NUM_REGS);
  localparam int WIN_AW = IDX_W + 2;

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] scsi_ctrl, net_ctrl, net_high;
  logic              wr_scsi_ctrl, wr_net_ctrl;

  assign idx          = bus_addr_i[WIN_AW-1:2];
  assign wr_scsi_ctrl = bus_we_i && (idx == IDX_W'(REG_SCSI_CTRL));
  assign wr_net_ctrl  = bus_we_i && (idx == IDX_W'(REG_NET_CTRL));

  ddc_reg_file #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .LEN_W(LEN_W)) i_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (bus_we_i),
    .idx_i        (idx),
    .wr_data_i    (bus_wdata_i),
    .xfer_i       (scsi_xfer_i),
    .xfer_len_i   (scsi_len_i),
    .scsi_raise_i (scsi_irq_raise_i),
    .scsi_clr_i   (scsi_irq_clear_i),
    .net_set_i    (net_irq_set_i),
    .rd_data_o    (bus_rdata_o),
    .scsi_ctrl_o  (scsi_ctrl),
    .scsi_addr_o  (scsi_mem_addr_o),
    .net_ctrl_o   (net_ctrl),
    .net_high_o   (net_high)
  );

  ddc_irq_line i_scsi_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (scsi_irq_raise_i),
    .clr_i  (scsi_irq_clear_i || (wr_scsi_ctrl && !bus_wdata_i[B_IEN])),
    .q_o    (scsi_irq_o)
  );

  ddc_irq_line i_net_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (net_irq_set_i),
    .clr_i  (wr_net_ctrl && !bus_wdata_i[B_IEN]),
    .q_o    (net_irq_o)
  );

  // one pulse per qualifying write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scsi_rst_o <= 1'b0;
      net_rst_o  <= 1'b0;
    end else begin
      scsi_rst_o <= wr_scsi_ctrl && bus_wdata_i[B_RST];
      net_rst_o  <= wr_net_ctrl  && bus_wdata_i[B_RST];
    end
  end

  assign scsi_dir_o     = scsi_ctrl[B_DIR];
  assign net_dir_o      = net_ctrl[B_DIR];
  assign net_mem_addr_o = net_addr_i | net_high;

  ddc_swap #(.W(NET_W)) i_swap_rd (.en_i(net_swap_i), .d_i(net_rdata_i), .d_o(net_rdata_o));
  ddc_swap #(.W(NET_W)) i_swap_wr (.en_i(net_swap_i), .d_i(net_wdata_i), .d_o(net_wdata_o));
endmodule

// File: rtl/dual_dma_ctrl_chk.sv
module dual_dma_ctrl_chk #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int BUS_AW   = 8,
  parameter int LEN_W    = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [BUS_AW-1:0] bus_addr_i,
  input logic              bus_we_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic              scsi_xfer_i,
  input logic [LEN_W-1:0]  scsi_len_i,
  input logic              scsi_irq_raise_i,
  input logic [DATA_W-1:0] scsi_mem_addr_o,
  input logic              scsi_irq_o,
  input logic              scsi_rst_o,
  input logic              net_irq_set_i,
  input logic              net_irq_o
);
  localparam int IDX_W  = $clog2(NUM_REGS);
  localparam int WIN_AW = IDX_W + 2;

  logic [IDX_W-1:0] c_idx;
  logic w0, w1, w4;
  assign c_idx = bus_addr_i[WIN_AW-1:2];
  assign w0 = bus_we_i && (c_idx == IDX_W'(0));
  assign w1 = bus_we_i && (c_idx == IDX_W'(1));
  assign w4 = bus_we_i && (c_idx == IDX_W'(4));

  a_r8_rst_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w0 && bus_wdata_i[7]) |=> scsi_rst_o);
  a_r8_rst_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(w0 && bus_wdata_i[7]) |=> !scsi_rst_o);
  a_r6_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scsi_irq_raise_i |=> scsi_irq_o);
  a_r7_ien_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w0 && !bus_wdata_i[4] && !scsi_irq_raise_i) |=> !scsi_irq_o);
  a_r9_net_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w4 && !bus_wdata_i[4] && !net_irq_set_i) |=> !net_irq_o);
  a_r5_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scsi_xfer_i && !w1) |=>
      scsi_mem_addr_o == $past(scsi_mem_addr_o) + DATA_W'($past(scsi_len_i)));
endmodule

bind dual_dma_ctrl dual_dma_ctrl_chk #(
  .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .BUS_AW(BUS_AW), .LEN_W(LEN_W)
) i_chk (.*);

// File: tb/test_dual_dma_ctrl.sv
module test_dual_dma_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata, bus_rdata;
  logic        scsi_xfer, scsi_raise, scsi_clear;
  logic [23:0] scsi_len;
  logic [31:0] scsi_mem_addr, net_addr, net_mem_addr;
  logic        scsi_dir, scsi_irq, scsi_rst;
  logic        net_set, net_dir, net_swap, net_irq, net_rst;
  logic [15:0] net_rd_in, net_rd_out, net_wr_in, net_wr_out;

  int vectors = 0;
  int errors  = 0;

  logic [31:0] m [8];
  logic        m_sirq, m_nirq, m_srst, m_nrst;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_dma_ctrl i_dual_dma_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_addr_i(bus_addr), .bus_we_i(bus_we), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .scsi_xfer_i(scsi_xfer), .scsi_len_i(scsi_len),
    .scsi_irq_raise_i(scsi_raise), .scsi_irq_clear_i(scsi_clear),
    .scsi_mem_addr_o(scsi_mem_addr), .scsi_dir_o(scsi_dir), .scsi_irq_o(scsi_irq), .scsi_rst_o(scsi_rst),
    .net_irq_set_i(net_set), .net_addr_i(net_addr), .net_mem_addr_o(net_mem_addr), .net_dir_o(net_dir),
    .net_swap_i(net_swap), .net_rdata_i(net_rd_in), .net_rdata_o(net_rd_out),
    .net_wdata_i(net_wr_in), .net_wdata_o(net_wr_out),
    .net_irq_o(net_irq), .net_rst_o(net_rst)
  );

  function automatic logic [15:0] sw(input logic [15:0] x, input logic en);
    return en ? {x[7:0], x[15:8]} : x;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    bus_addr = 8'h00; bus_we = 1'b0; bus_wdata = '0;
    scsi_xfer = 1'b0; scsi_len = '0; scsi_raise = 1'b0; scsi_clear = 1'b0;
    net_set = 1'b0; net_addr = '0; net_swap = 1'b0; net_rd_in = '0; net_wr_in = '0;
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m[i] = 32'h0;
    m[0] = 32'hA000_0000; m[4] = 32'hA000_0000;
    m_sirq = 0; m_nirq = 0; m_srst = 0; m_nrst = 0;
  endtask

  // compare mid-cycle, then advance model at the edge
  task automatic tick(input string tag);
    int idx;
    logic [31:0] n [8];
    idx = (int'(bus_addr) >> 2) & 7;
    #(CLK_PERIOD/4);
    chk(tag, "rdata", bus_rdata, m[idx]);
    chk(tag, "scsi_mem_addr", scsi_mem_addr, m[1]);
    chk(tag, "net_mem_addr", net_mem_addr, net_addr | m[7]);
    chk(tag, "dirs", {30'd0, scsi_dir, net_dir}, {30'd0, m[0][8], m[4][8]});
    chk(tag, "irqs", {30'd0, scsi_irq, net_irq}, {30'd0, m_sirq, m_nirq});
    chk(tag, "rsts", {30'd0, scsi_rst, net_rst}, {30'd0, m_srst, m_nrst});
    chk(tag, "swap", {net_rd_out, net_wr_out}, {sw(net_rd_in, net_swap), sw(net_wr_in, net_swap)});
    @(posedge clk);
    for (int i = 0; i < 8; i++) n[i] = m[i];
    if (bus_we) n[idx] = bus_wdata;
    if (scsi_xfer && !(bus_we && idx == 1)) n[1] = m[1] + {8'h00, scsi_len};
    if (bus_we && idx == 1) n[0][26] = 1'b1;
    if (scsi_clear) n[0][0] = 1'b0;
    if (scsi_raise || scsi_xfer) n[0][0] = 1'b1;
    if (net_set) n[4][0] = 1'b1;
    if (scsi_raise) m_sirq = 1'b1;
    else if (scsi_clear || (bus_we && idx == 0 && !bus_wdata[4])) m_sirq = 1'b0;
    if (net_set) m_nirq = 1'b1;
    else if (bus_we && idx == 4 && !bus_wdata[4]) m_nirq = 1'b0;
    m_srst = bus_we && idx == 0 && bus_wdata[7];
    m_nrst = bus_we && idx == 4 && bus_wdata[7];
    for (int i = 0; i < 8; i++) m[i] = n[i];
    @(negedge clk);
  endtask

  task automatic wr(input string tag, input logic [7:0] a, input logic [31:0] d);
    idle(); bus_addr = a; bus_we = 1'b1; bus_wdata = d; tick(tag);
  endtask

  task automatic rd(input string tag, input logic [7:0] a);
    idle(); bus_addr = a; tick(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    idle();
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset image
    for (int i = 0; i < 8; i++) rd("R1", 8'(i * 4));
    // R2 store, alias and byte-offset decode, read has no effect
    wr("R2", 8'h08, 32'h1234_5678);
    rd("R2", 8'h28);
    rd("R2", 8'h0B);
    rd("R2", 8'hE9);
    wr("R2", 8'h34, 32'hCAFE_F00D);
    rd("R2", 8'h14);
    // R3 direction bits
    wr("R3", 8'h00, 32'h0000_0100);
    wr("R3", 8'h10, 32'h0000_0100);
    rd("R3", 8'h00);
    // R4 loaded flag
    wr("R4", 8'h04, 32'h0000_1000);
    rd("R4", 8'h00);
    // R5 burst advance, wrap, and collision with address write
    idle(); scsi_xfer = 1'b1; scsi_len = 24'h40; tick("R5");
    rd("R5", 8'h04);
    rd("R5", 8'h00);
    idle(); bus_addr = 8'h04; bus_we = 1'b1; bus_wdata = 32'h2000; scsi_xfer = 1'b1; scsi_len = 24'h8; tick("R5");
    rd("R5", 8'h04);
    rd("R5", 8'h00);
    wr("R5", 8'h04, 32'hFFFF_FFF0);
    idle(); scsi_xfer = 1'b1; scsi_len = 24'hFF_FF20; tick("R5");
    idle(); scsi_xfer = 1'b1; scsi_len = 24'h3; tick("R5");
    rd("R5", 8'h04);
    // R6 raise / clear / both
    wr("R6", 8'h00, 32'h0);
    idle(); scsi_raise = 1'b1; tick("R6");
    rd("R6", 8'h00);
    idle(); scsi_clear = 1'b1; tick("R6");
    rd("R6", 8'h00);
    idle(); scsi_raise = 1'b1; scsi_clear = 1'b1; tick("R6");
    rd("R6", 8'h00);
    // R7 enable-clear write drops; enable-set keeps; raise collision keeps
    wr("R7", 8'h00, 32'h0000_0010);
    rd("R7", 8'h00);
    wr("R7", 8'h00, 32'h0000_0000);
    rd("R7", 8'h00);
    idle(); bus_we = 1'b1; bus_wdata = 32'h0; scsi_raise = 1'b1; tick("R7");
    rd("R7", 8'h00);
    idle(); bus_we = 1'b1; bus_wdata = 32'h0; scsi_xfer = 1'b1; scsi_len = 24'h1; tick("R7");
    rd("R7", 8'h00);
    // R8 reset pulses
    wr("R8", 8'h00, 32'h0000_0090);
    rd("R8", 8'h00);
    rd("R8", 8'h00);
    wr("R8", 8'h10, 32'h0000_0080);
    rd("R8", 8'h10);
    wr("R8", 8'h00, 32'h0000_0080);
    wr("R8", 8'h00, 32'h0000_0080);
    rd("R8", 8'h00);
    // R9 network interrupt
    idle(); net_set = 1'b1; tick("R9");
    rd("R9", 8'h10);
    wr("R9", 8'h10, 32'h0000_0010);
    wr("R9", 8'h10, 32'h0000_0000);
    idle(); net_set = 1'b1; tick("R9");
    idle(); bus_addr = 8'h10; bus_we = 1'b1; net_set = 1'b1; tick("R9");
    rd("R9", 8'h10);
    // R10 high address OR
    wr("R10", 8'h1C, 32'hFF00_0000);
    idle(); bus_addr = 8'h1C; net_addr = 32'h0012_3456; tick("R10");
    idle(); net_addr = 32'hF0F0_0001; tick("R10");
    // R11 byte swap both directions
    idle(); net_swap = 1'b1; net_rd_in = 16'hA1B2; net_wr_in = 16'h3C4D; tick("R11");
    idle(); net_swap = 1'b0; net_rd_in = 16'hA1B2; net_wr_in = 16'h3C4D; tick("R11");
    idle(); net_swap = 1'b1; net_rd_in = 16'h00FF; net_wr_in = 16'hFF00; tick("R11");
    rd("R2", 8'h00);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule